// File: doc/BRIEF.md
# Single-Block Key Hashing Core

This core turns one 32-bit key into a 256-bit SHA-256 digest and a 128-bit key for a following block cipher. A caller offers the key on a valid/ready input. Once the key is taken, the core builds the one padded 512-bit block on its own, runs the 64 compression rounds one per clock, adds the initial hash words back in, and raises a one-cycle completion pulse. The derived cipher key is the upper half of the digest.

Back-pressure rules: `in_ready` is high only while the core is idle. A key transfers on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_key` are ignored and nothing is queued, so a caller must keep its key offered until it is taken. The output side has no back-pressure. The digest and derived key are held in registers and change only on the cycle the completion pulse rises.

Top module: `kdh_hash_core`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, and `digest` and `dkey` are all zeros.
- R2: A key is taken on the rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle in which `done` is 1.
- R3: `in_valid` and `in_key` have no effect while `in_ready` is 0. The result depends only on the key that was taken.
- R4: The hashed block has the key as word 0 and 0x80000000 as word 1. Words 2 to 14 are zero, and word 15 holds the bit length, 32.
- R5: `digest` equals the SHA-256 value of that block. This uses the standard initial hash words and a final modulo 2^32 addition. Word H0 sits in bits 255:224 and H7 sits in bits 31:0.
- R6: `done` rises on the 64th rising edge after the accepting edge. That is, it is high during the 65th cycle counted from the accepting edge.
- R7: `done` is high for exactly one cycle, and `in_ready` is 1 in that cycle. A new key offered in that cycle is taken at the next edge.
- R8: `dkey` equals `digest[255:128]`.
- R9: `digest` and `dkey` change only on the edge that raises `done`. They hold their values while the core is idle or busy with a later key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Key offered |
| in_ready | output | 1 | Core idle and able to take a key |
| in_key | input | 32 | Key to hash |
| done | output | 1 | One-cycle pulse when a new result is loaded |
| digest | output | 256 | Full hash result, H0 in the top word |
| dkey | output | DKEY_W (128) | Derived cipher key |

## Verification
Two events can fall in the same cycle: the completion of one hash, and the acceptance of the next key. Back-to-back runs provoke this by offering a fresh key in exactly the cycle where `done` is high. Each run is then judged on its own. The first digest must match the reference model of its own key. The second run must also keep the full latency and yield the digest of the second key. In addition, random keys are driven with `in_valid` held high throughout busy periods, to show that those offers leave the result untouched.

// File: rtl/kdh_pkg.sv
package kdh_pkg;
  localparam int WORD_W  = 32;
  localparam int NROUNDS = 64;
  localparam int WIN     = 16;
  localparam int RND_W   = $clog2(NROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } hstate_t;

  localparam hstate_t H_INIT = '{
    a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
    e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19};

  localparam word_t PAD_MARK = 32'h8000_0000;
  localparam word_t PAD_LEN  = word_t'(WORD_W);

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sig_lo0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sig_lo1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t sig_up0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t sig_up1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic hstate_t fold_in(input hstate_t x, input hstate_t y);
    hstate_t r;
    r.a = x.a + y.a; r.b = x.b + y.b; r.c = x.c + y.c; r.d = x.d + y.d;
    r.e = x.e + y.e; r.f = x.f + y.f; r.g = x.g + y.g; r.h = x.h + y.h;
    return r;
  endfunction

  function automatic word_t round_k(input logic [RND_W-1:0] i);
    case (i)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction
endpackage

// File: rtl/kdh_sched.sv
module kdh_sched
  import kdh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  word_t key,
  output word_t w_cur
);
  word_t win [WIN];
  word_t w_new;

  assign w_cur = win[0];
  assign w_new = sig_lo1(win[WIN-2]) + win[WIN-7] + sig_lo0(win[1]) + win[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < WIN; i++) begin
        if (i == 0)            win[i] <= key;
        else if (i == 1)       win[i] <= PAD_MARK;
        else if (i == WIN - 1) win[i] <= PAD_LEN;
        else                   win[i] <= '0;
      end
    end else if (step) begin
      for (int i = 0; i < WIN - 1; i++) win[i] <= win[i+1];
      win[WIN-1] <= w_new;
    end
  end
endmodule

// File: rtl/kdh_round.sv
module kdh_round
  import kdh_pkg::*;
(
  input  hstate_t st_in,
  input  word_t   w,
  input  word_t   k,
  output hstate_t st_out
);
  word_t t1, t2, ch, mj;

  always_comb begin
    ch = (st_in.e & st_in.f) ^ (~st_in.e & st_in.g);
    mj = (st_in.a & st_in.b) ^ (st_in.a & st_in.c) ^ (st_in.b & st_in.c);
    t1 = st_in.h + sig_up1(st_in.e) + ch + k + w;
    t2 = sig_up0(st_in.a) + mj;
    st_out.a = t1 + t2;
    st_out.b = st_in.a;
    st_out.c = st_in.b;
    st_out.d = st_in.c;
    st_out.e = st_in.d + t1;
    st_out.f = st_in.e;
    st_out.g = st_in.f;
    st_out.h = st_in.g;
  end
endmodule

// File: rtl/kdh_ctrl.sv
module kdh_ctrl
  import kdh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic [RND_W-1:0] rnd
);
  localparam logic [RND_W-1:0] RND_END = RND_W'(NROUNDS - 1);

  assign accept = in_valid && !busy;
  assign last   = busy && (rnd == RND_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rnd  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      rnd  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      rnd  <= rnd + 1'b1;
    end
  end
endmodule

// File: rtl/kdh_hash_core.sv
module kdh_hash_core
  import kdh_pkg::*;
#(
  parameter int DKEY_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         in_key,
  output logic                done,
  output logic [255:0]        digest,
  output logic [DKEY_W-1:0]   dkey
);
  localparam int DIG_W = $bits(hstate_t);

  logic             accept, busy, last;
  logic [RND_W-1:0] rnd;
  word_t            w_cur;
  hstate_t          st, st_nx;

  kdh_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .accept(accept), .busy(busy), .last(last), .rnd(rnd)
  );

  kdh_sched u_sched (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(busy),
    .key(in_key), .w_cur(w_cur)
  );

  kdh_round u_round (
    .st_in(st), .w(w_cur), .k(round_k(rnd)), .st_out(st_nx)
  );

  assign in_ready = !busy;
  assign dkey     = digest[DIG_W-1 -: DKEY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= '0;
      digest <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept)    st <= H_INIT;
      else if (busy) st <= st_nx;
      if (last) begin
        digest <= fold_in(H_INIT, st_nx);
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kdh_hash_chk.sv
module kdh_hash_chk
  import kdh_pkg::*;
#(
  parameter int DKEY_W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [255:0] digest
);
  localparam int LAT = NROUNDS + 1;
  logic take;
  logic [7:0] lat_cnt;

  assign take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (take)             lat_cnt <= 8'd1;
    else if (lat_cnt != 8'd0 && lat_cnt != 8'hff) lat_cnt <= lat_cnt + 8'd1;
  end

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  a_r9_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 8'(LAT)));
endmodule

bind kdh_hash_core kdh_hash_chk #(.DKEY_W(DKEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .digest(digest)
);

// File: tb/kdh_hash_core_bench.sv
module kdh_hash_core_bench;
  localparam int DKEY_W = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_key = '0;
  logic done;
  logic [255:0] digest;
  logic [DKEY_W-1:0] dkey;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [255:0] held;

  always #5 clk = ~clk;

  kdh_hash_core #(.DKEY_W(DKEY_W)) u_kdh_hash_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .done(done), .digest(digest), .dkey(dkey)
  );

  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  localparam logic [31:0] HI [8] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // Reference model: R4 block layout, R5 full hash
  function automatic logic [255:0] ref_hash(input logic [31:0] key);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    for (int i = 0; i < 16; i++) w[i] = 32'h0;
    w[0] = key;
    w[1] = 32'h8000_0000;
    w[15] = 32'd32;
    for (int i = 16; i < 64; i++)
      w[i] = (ror(w[i-2], 17) ^ ror(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
           + (ror(w[i-15], 7) ^ ror(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int i = 0; i < 8; i++) v[i] = HI[i];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (ror(v[4], 6) ^ ror(v[4], 11) ^ ror(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KT[t] + w[t];
      t2 = (ror(v[0], 2) ^ ror(v[0], 13) ^ ror(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    return {v[0] + HI[0], v[1] + HI[1], v[2] + HI[2], v[3] + HI[3],
            v[4] + HI[4], v[5] + HI[5], v[6] + HI[6], v[7] + HI[7]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the falling edge where done is seen.
  task automatic run_key(input logic [31:0] key, input bit junk);
    logic [255:0] exp;
    int cyc;
    bit seen, ready_bad;
    exp = ref_hash(key);
    chk(in_ready === 1'b1, "R2", "ready before offer", 256'(in_ready), 256'd1);
    in_valid = 1'b1;
    in_key = key;
    cyc = 0;
    seen = 0;
    ready_bad = 0;
    while (!seen && cyc < 80) begin
      @(negedge clk);
      cyc++;
      if (done) seen = 1;
      else begin
        if (in_ready !== 1'b0) ready_bad = 1;
        if (junk) begin
          in_valid = 1'b1;   // R3: offers while busy must be ignored
          in_key = $urandom;
        end else begin
          in_valid = 1'b0;
        end
      end
    end
    in_valid = 1'b0;
    chk(cyc == 65, "R6", "cycles to done", 256'(cyc), 256'd65);
    chk(!ready_bad, "R2", "ready low while busy", 256'(ready_bad), 256'd0);
    chk(digest === exp, junk ? "R3 R5" : "R5 R4", "digest", digest, exp);
    chk(dkey === exp[255:128], "R8", "derived key", 256'(dkey), 256'(exp[255:128]));
    chk(in_ready === 1'b1, "R7", "ready during done", 256'(in_ready), 256'd1);
    held = digest;
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(done === 1'b0, "R7", "done width", 256'(done), 256'd0);
    for (int i = 0; i < 3; i++) begin
      in_key = $urandom;
      @(negedge clk);
    end
    chk(digest === held, "R9", "digest held idle", digest, held);
    chk(dkey === held[255:128], "R9", "dkey held idle", 256'(dkey), 256'(held[255:128]));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "reset ready", 256'(in_ready), 256'd1);
    chk(done === 1'b0, "R1", "reset done", 256'(done), 256'd0);
    chk(digest === '0, "R1", "reset digest", digest, 256'd0);
    chk(dkey === '0, "R1", "reset dkey", 256'(dkey), 256'd0);

    run_key(32'h0000_0000, 1'b0); idle_check();
    run_key(32'hffff_ffff, 1'b1); idle_check();
    run_key(32'h8000_0000, 1'b0); idle_check();
    run_key(32'h0000_0001, 1'b1); idle_check();
    // R7: next key offered in the done cycle (back-to-back)
    run_key(32'hdead_beef, 1'b0);
    run_key(32'h1234_5678, 1'b1);
    run_key(32'h0000_0000, 1'b0); idle_check();
    for (int n = 0; n < 10; n++) begin
      run_key($urandom, n[0]);
      if (n % 3 != 2) idle_check();
    end
    idle_check();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish act=hung exp=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule